// File: doc/BRIEF.md
# Per-Sequence Result FIFO Bank

This block holds the conversion results of four sample sequences, each in its own FIFO. The FIFOs differ in size: sequence 0 holds 8 entries, sequences 1 and 2 hold 4 entries each, and sequence 3 holds a single entry. The sequencer pushes a result into a sequence's FIFO by pulsing that sequence's write strobe, with the sample on a shared data bus. The host pops results one at a time by naming a sequence. It can take whatever is present at any moment, even while a sequence is still capturing.

Each FIFO shows its entry count and an empty flag. Two shared status bitmaps record misuse, with bit n belonging to sequence n. The overflow bitmap records a write that arrived while that FIFO was full and no read freed a slot in the same cycle. The underflow bitmap records a read from an empty FIFO. Both bits are sticky. The host clears them by pulsing a mask in which each 1 clears the matching bit. A FIFO that overflows drops the incoming sample and keeps its stored contents. A read from an empty FIFO returns zero.

Top module: `seq_result_fifo_bank`

## Requirements
- R1: Sequences 0, 1, 2 and 3 accept up to 8, 4, 4 and 1 results respectively, and a level never exceeds that depth.
- R2: A host read (hostRdEn with hostRdSeq = n) of a non-empty FIFO n removes the oldest entry. That entry appears on rdData after the next rising edge. rdData holds its value until the next read.
- R3: levelFlat[4n+3:4n] equals the number of entries held by sequence n, and emptyFlags[n] is 1 exactly when that number is zero. Both are updated at the edge that performs the push or pop.
- R4: A write to a full FIFO with no read of the same FIFO in that cycle sets ovfStat[n] at the next edge. The sample is dropped, and the level and stored contents are unchanged.
- R5: A read of an empty FIFO sets unfStat[n] at the next edge, loads rdData with zero, and leaves the level unchanged.
- R6: Status bits stay set until cleared. A 1 in ovfClr[n] or unfClr[n] clears only that bit, and a 0 leaves the bit as it was.
- R7: When an overflow or underflow event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: A write and a read of the same full FIFO in the same cycle both take effect. No overflow is flagged, the level stays at its depth, and rdData gets the oldest entry.
- R9: After reset all levels are 0, all empty flags are 1, both status bitmaps are 0 and rdData is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 4 | Per-sequence push strobe from the sequencer |
| wrData | input | DATA_W | Result sample written by any strobe |
| hostRdEn | input | 1 | Host pop request |
| hostRdSeq | input | 2 | Sequence selected for the pop |
| ovfClr | input | 4 | Write-1-to-clear mask for the overflow bits |
| unfClr | input | 4 | Write-1-to-clear mask for the underflow bits |
| rdData | output | DATA_W | Result of the latest pop, or 0 after an empty read |
| levelFlat | output | 4*CNT_W | Entry count per sequence, sequence n at [CNT_W*n +: CNT_W] |
| emptyFlags | output | 4 | Per-sequence empty indication |
| ovfStat | output | 4 | Sticky overflow bitmap |
| unfStat | output | 4 | Sticky underflow bitmap |

## Verification
Directed phases fill every FIFO to its own depth and push one sample too many. Draining sequence 0 then shows that the dropped sample never displaced stored data and that order is preserved. A read past empty follows, which separates the underflow path from normal pops. Single-bit clears show that one bit can be cleared without disturbing its neighbour. A clear issued in the same cycle as a new event, and a push and pop together on the one-entry FIFO, pin down the two same-cycle priorities. A long random run with all four sequences competing then checks every output against a queue model on every clock. That run covers sequences written at the same time and partial reads while capture continues.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  parameter int NUM_SEQ = 4;
  parameter int SEL_W = 2;

  typedef struct packed {
    logic [NUM_SEQ-1:0] push;
    logic [NUM_SEQ-1:0] pop;
    logic               rdFire;
    logic [SEL_W-1:0]   rdSel;
  } rfbStrobe_t;

  function automatic int ptrWidth(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/rfb_ctrl.sv
module rfb_ctrl
  import rfb_pkg::*;
#(
  parameter int DEPTHS [NUM_SEQ] = '{8, 4, 4, 1},
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SEQ-1:0]       wrStrobe,
  input  logic                     hostRdEn,
  input  logic [SEL_W-1:0]         hostRdSeq,
  input  logic [NUM_SEQ-1:0]       ovfClr,
  input  logic [NUM_SEQ-1:0]       unfClr,
  output rfbStrobe_t               strobe,
  output logic [NUM_SEQ*CNT_W-1:0] levelFlat,
  output logic [NUM_SEQ-1:0]       emptyFlags,
  output logic [NUM_SEQ-1:0]       ovfStat,
  output logic [NUM_SEQ-1:0]       unfStat
);
  logic [CNT_W-1:0]   cnt [NUM_SEQ];
  logic [NUM_SEQ-1:0] popReq, doPop, doPush, ovfEvt, unfEvt, fullNow;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : gSeq
    assign popReq[g]  = hostRdEn && (hostRdSeq == SEL_W'(g));
    assign fullNow[g] = (cnt[g] == CNT_W'(DEPTHS[g]));
    assign doPop[g]   = popReq[g] && (cnt[g] != '0);
    assign unfEvt[g]  = popReq[g] && (cnt[g] == '0);
    assign doPush[g]  = wrStrobe[g] && (!fullNow[g] || doPop[g]);
    assign ovfEvt[g]  = wrStrobe[g] && !doPush[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[g] <= '0;
      end else if (doPush[g] && !doPop[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
      end else if (!doPush[g] && doPop[g]) begin
        cnt[g] <= cnt[g] - 1'b1;
      end
    end

    assign levelFlat[g*CNT_W +: CNT_W] = cnt[g];
    assign emptyFlags[g] = (cnt[g] == '0);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= CNT_W'(DEPTHS[g]));
    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfStat[g]) |-> $past(wrStrobe[g]));
    // R4
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrStrobe[g] && fullNow[g] && !popReq[g]) |=> $stable(cnt[g]));
    // R5
    unf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (popReq[g] && cnt[g] == '0 && !wrStrobe[g]) |=> (cnt[g] == '0));
    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ovfStat[g]) |-> $past(ovfClr[g]));
    // R6
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(unfStat[g]) |-> $past(unfClr[g]));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrStrobe[g] && fullNow[g] && !popReq[g]) |=> ovfStat[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfStat <= '0;
      unfStat <= '0;
    end else begin
      ovfStat <= ovfEvt | (ovfStat & ~ovfClr);
      unfStat <= unfEvt | (unfStat & ~unfClr);
    end
  end

  assign strobe.push   = doPush;
  assign strobe.pop    = doPop;
  assign strobe.rdFire = hostRdEn;
  assign strobe.rdSel  = hostRdSeq;
endmodule

// File: rtl/rfb_datapath.sv
module rfb_datapath
  import rfb_pkg::*;
#(
  parameter int DEPTHS [NUM_SEQ] = '{8, 4, 4, 1},
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfbStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] headData [NUM_SEQ];

  for (genvar g = 0; g < NUM_SEQ; g++) begin : gStore
    localparam int PW = ptrWidth(DEPTHS[g]);
    localparam logic [PW-1:0] LAST = PW'(DEPTHS[g] - 1);

    logic [DATA_W-1:0] mem [DEPTHS[g]];
    logic [PW-1:0]     wrPtr, rdPtr;

    always_ff @(posedge clk) begin
      if (strobe.push[g]) begin
        mem[wrPtr] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe.push[g]) begin
          wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
        end
        if (strobe.pop[g]) begin
          rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
        end
      end
    end

    assign headData[g] = mem[rdPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdFire) begin
      rdData <= strobe.pop[strobe.rdSel] ? headData[strobe.rdSel] : '0;
    end
  end

  // R2
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.pop));
  // R2
  pop_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop != '0) |-> (strobe.rdFire && strobe.pop[strobe.rdSel]));
endmodule

// File: rtl/seq_result_fifo_bank.sv
module seq_result_fifo_bank
  import rfb_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH0 = 8,
  parameter int DEPTH1 = 4,
  parameter int DEPTH2 = 4,
  parameter int DEPTH3 = 1,
  localparam int MAX01 = (DEPTH0 > DEPTH1) ? DEPTH0 : DEPTH1,
  localparam int MAX23 = (DEPTH2 > DEPTH3) ? DEPTH2 : DEPTH3,
  localparam int MAX_D = (MAX01 > MAX23) ? MAX01 : MAX23,
  localparam int CNT_W = $clog2(MAX_D + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SEQ-1:0]       wrStrobe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     hostRdEn,
  input  logic [SEL_W-1:0]         hostRdSeq,
  input  logic [NUM_SEQ-1:0]       ovfClr,
  input  logic [NUM_SEQ-1:0]       unfClr,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_SEQ*CNT_W-1:0] levelFlat,
  output logic [NUM_SEQ-1:0]       emptyFlags,
  output logic [NUM_SEQ-1:0]       ovfStat,
  output logic [NUM_SEQ-1:0]       unfStat
);
  localparam int DEPTHS [NUM_SEQ] = '{DEPTH0, DEPTH1, DEPTH2, DEPTH3};

  rfbStrobe_t strobe;

  rfb_ctrl #(.DEPTHS(DEPTHS), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .hostRdEn(hostRdEn),
    .hostRdSeq(hostRdSeq), .ovfClr(ovfClr), .unfClr(unfClr),
    .strobe(strobe), .levelFlat(levelFlat), .emptyFlags(emptyFlags),
    .ovfStat(ovfStat), .unfStat(unfStat)
  );

  rfb_datapath #(.DEPTHS(DEPTHS), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/test_seq_result_fifo_bank.sv
module test_seq_result_fifo_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int NSEQ = 4;
  localparam int LW = 4;
  localparam int depthOf [NSEQ] = '{8, 4, 4, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSEQ-1:0] wrStrobe = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic hostRdEn = 1'b0;
  logic [1:0] hostRdSeq = '0;
  logic [NSEQ-1:0] ovfClr = '0, unfClr = '0;
  logic [DATA_W-1:0] rdData;
  logic [NSEQ*LW-1:0] levelFlat;
  logic [NSEQ-1:0] emptyFlags, ovfStat, unfStat;

  seq_result_fifo_bank i_seq_result_fifo_bank (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .hostRdEn(hostRdEn), .hostRdSeq(hostRdSeq), .ovfClr(ovfClr),
    .unfClr(unfClr), .rdData(rdData), .levelFlat(levelFlat),
    .emptyFlags(emptyFlags), .ovfStat(ovfStat), .unfStat(unfStat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int fifoQ [NSEQ][$];
  bit ovfM [NSEQ];
  bit unfM [NSEQ];
  int rdM = 0;

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int levelOf(input int s);
    return int'(levelFlat[s*LW +: LW]);
  endfunction

  task automatic modelStep();
    bit ovfEvt [NSEQ];
    bit unfEvt [NSEQ];
    for (int s = 0; s < NSEQ; s++) begin
      ovfEvt[s] = 0;
      unfEvt[s] = 0;
    end
    if (hostRdEn) begin
      if (fifoQ[hostRdSeq].size() > 0) rdM = fifoQ[hostRdSeq].pop_front();
      else begin
        rdM = 0;
        unfEvt[hostRdSeq] = 1;
      end
    end
    for (int s = 0; s < NSEQ; s++) begin
      if (wrStrobe[s]) begin
        if (fifoQ[s].size() < depthOf[s]) fifoQ[s].push_back(int'(wrData));
        else ovfEvt[s] = 1;
      end
      ovfM[s] = ovfEvt[s] | (ovfM[s] & !ovfClr[s]);
      unfM[s] = unfEvt[s] | (unfM[s] & !unfClr[s]);
    end
  endtask

  task automatic compareAll();
    for (int s = 0; s < NSEQ; s++) begin
      checkEq("R3", $sformatf("level%0d", s), levelOf(s), fifoQ[s].size());
      checkEq("R3", $sformatf("empty%0d", s), int'(emptyFlags[s]), int'(fifoQ[s].size() == 0));
      checkEq("R4", $sformatf("ovf%0d", s), int'(ovfStat[s]), int'(ovfM[s]));
      checkEq("R5", $sformatf("unf%0d", s), int'(unfStat[s]), int'(unfM[s]));
    end
    checkEq("R2", "rdData", int'(rdData), rdM);
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    wrStrobe = '0; hostRdEn = 1'b0; ovfClr = '0; unfClr = '0;
  endtask

  task automatic push(input int s, input int d);
    wrStrobe[s] = 1'b1; wrData = DATA_W'(d);
    cycle();
  endtask

  task automatic pop(input int s);
    hostRdEn = 1'b1; hostRdSeq = 2'(s);
    cycle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < NSEQ; s++) begin ovfM[s] = 0; unfM[s] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    for (int s = 0; s < NSEQ; s++) begin
      checkEq("R9", "level", levelOf(s), 0);
      checkEq("R9", "empty", int'(emptyFlags[s]), 1);
    end
    checkEq("R9", "ovfStat", int'(ovfStat), 0);
    checkEq("R9", "unfStat", int'(unfStat), 0);
    checkEq("R9", "rdData", int'(rdData), 0);

    // R1 fill each sequence to its own depth
    for (int k = 0; k < 8; k++) push(0, 100 + k);
    for (int k = 0; k < 4; k++) push(1, 200 + k);
    for (int k = 0; k < 4; k++) push(2, 250 + k);
    push(3, 300);
    checkEq("R1", "level0", levelOf(0), 8);
    checkEq("R1", "level1", levelOf(1), 4);
    checkEq("R1", "level2", levelOf(2), 4);
    checkEq("R1", "level3", levelOf(3), 1);

    // R4 one write too many
    push(0, 999);
    checkEq("R4", "ovf0", int'(ovfStat[0]), 1);
    checkEq("R4", "level0 after drop", levelOf(0), 8);

    // R2 drain in order
    for (int k = 0; k < 8; k++) begin
      pop(0);
      checkEq("R2", "drain data", int'(rdData), 100 + k);
    end

    // R5 read past empty
    pop(0);
    checkEq("R5", "unf0", int'(unfStat[0]), 1);
    checkEq("R5", "empty read data", int'(rdData), 0);
    checkEq("R5", "level0 after empty read", levelOf(0), 0);

    // R6 clear one bitmap bit at a time
    ovfClr = 4'b0001; cycle();
    checkEq("R6", "ovf0 cleared", int'(ovfStat[0]), 0);
    checkEq("R6", "unf0 kept", int'(unfStat[0]), 1);
    unfClr = 4'b0010; cycle();
    checkEq("R6", "unf0 with zero mask bit", int'(unfStat[0]), 1);
    unfClr = 4'b0001; cycle();
    checkEq("R6", "unf0 cleared", int'(unfStat[0]), 0);

    // R7 event and clear in the same cycle
    wrStrobe[3] = 1'b1; wrData = 12'd55; ovfClr = 4'b1000; cycle();
    checkEq("R7", "ovf3 set wins", int'(ovfStat[3]), 1);
    ovfClr = 4'b1000; cycle();
    checkEq("R7", "ovf3 cleared", int'(ovfStat[3]), 0);

    // R8 push and pop on a full FIFO together
    wrStrobe[3] = 1'b1; wrData = 12'd77; hostRdEn = 1'b1; hostRdSeq = 2'd3; cycle();
    checkEq("R8", "ovf3", int'(ovfStat[3]), 0);
    checkEq("R8", "level3", levelOf(3), 1);
    checkEq("R8", "rdData", int'(rdData), 300);
    pop(3);
    checkEq("R8", "new data", int'(rdData), 77);

    // random run, all sequences competing
    for (int n = 0; n < 4000; n++) begin
      for (int s = 0; s < NSEQ; s++) wrStrobe[s] = ($urandom % 10) < 3;
      wrData = DATA_W'($urandom);
      hostRdEn = ($urandom % 2) == 0;
      hostRdSeq = 2'($urandom);
      if (($urandom % 8) == 0) ovfClr = 4'($urandom);
      if (($urandom % 8) == 0) unfClr = 4'($urandom);
      cycle();
    end

    summary();
    $finish;
  end
endmodule